// File: doc/BRIEF.md
# Memory Power-Down Entry and Exit Sequencer

This block sits on the host side of a low-power pseudo-static memory. It drives the memory's active-high chip enable, which is called the power enable here. It also holds the memory's active-low chip enable inactive through an override output. The block walks the memory through three sequences: first start-up, entry into the low-power idle state, and exit from that state. While the power enable is low the memory sits in its idle state and its data pins float. Accesses may resume only after a recovery hold has elapsed.

The access controller sees a single ready output. Ready falls when a sleep request is accepted and stays low until the recovery hold after wake-up has expired. Power-down is entered only from standby: the chip enable override is raised some cycles before the power enable falls. A wake request that comes too early is remembered and acted on once the minimum low time has passed.

The length of the recovery hold depends on the retention mode. After full sleep the hold is long. When a partial-retention mode is in force the hold is short. The mode flag is taken at the moment the sleep request is accepted. The start-up path always uses the long hold. A sleep then wake pass can also be used to reset the memory when start-up timing could not be met. All times are counted in clock cycles and set by parameters.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset, power enable is low, the chip enable override is high and ready is low. This holds until start is sampled high. Sleep and wake requests in this state have no effect.
- R2: After start is sampled, power enable stays low for exactly PWRUP_LOW_CYC cycles and then rises.
- R3: After power enable rises at start-up, the override stays high and ready stays low for exactly FULL_HOLD_CYC cycles. Ready then rises and the override falls in the same cycle.
- R4: A sleep request is accepted only while ready is high. On acceptance, ready falls and the override rises. Power enable stays high for exactly SETUP_CYC further cycles and then falls.
- R5: Power enable stays low for at least LOW_MIN_CYC cycles. Suppose a wake request is sampled in the j-th low cycle, counting from 1. Then the low time is max(LOW_MIN_CYC, j) cycles: an early wake is deferred, not dropped.
- R6: After a wake-up, the override stays high and ready stays low for FULL_HOLD_CYC cycles when the mode flag was 0 at sleep acceptance, and for PART_HOLD_CYC cycles when it was 1. Changes to the flag after acceptance have no effect.
- R7: Sleep requests while ready is low, start while not in the reset state, and wake requests while ready is high are ignored. Power enable and ready do not change as a result.
- R8: Whenever ready is high, power enable is high and the override is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the start-up sequence |
| sleep_req_i | input | 1 | Request entry into power-down |
| wake_req_i | input | 1 | Request exit from power-down |
| partial_i | input | 1 | 1 when a partial-retention mode is programmed |
| ce2_o | output | 1 | Power enable to the memory (low = power-down) |
| ce1_hold_o | output | 1 | Forces the memory's active-low chip enable inactive |
| ready_o | output | 1 | Memory may be accessed |

## Verification
The hardest case to reach is the boundary between a deferred wake and an immediate one. This happens when the wake request lands in the very last cycle of the minimum low window, or in the cycle just after it. To reach it, the bench watches power enable from the falling edge onward and counts the low cycles. It fires a single-cycle wake at a chosen count j, sweeping j from 1 to three past the minimum, for each setting of the mode flag. In every pass the bench inverts the mode flag right after the sleep request is accepted, so that a hold length taken from the live flag would be detected.

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
  parameter int SETUP_CYC     = 1,
  parameter int LOW_MIN_CYC   = 7,
  parameter int PWRUP_LOW_CYC = 5000,
  parameter int FULL_HOLD_CYC = 30000,
  parameter int PART_HOLD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  input  logic partial_i,
  output logic ce2_o,
  output logic ce1_hold_o,
  output logic ready_o
);
  localparam int M1   = (SETUP_CYC > LOW_MIN_CYC) ? SETUP_CYC : LOW_MIN_CYC;
  localparam int M2   = (PWRUP_LOW_CYC > FULL_HOLD_CYC) ? PWRUP_LOW_CYC : FULL_HOLD_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > PART_HOLD_CYC) ? M3 : PART_HOLD_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_LOW   = CW'(LOW_MIN_CYC - 1);
  localparam logic [CW-1:0] L_PWRUP = CW'(PWRUP_LOW_CYC - 1);
  localparam logic [CW-1:0] L_FULL  = CW'(FULL_HOLD_CYC - 1);
  localparam logic [CW-1:0] L_PART  = CW'(PART_HOLD_CYC - 1);

  typedef enum logic [2:0] {S_OFF, S_PUP, S_HOLD, S_RDY, S_PRE, S_LOWMIN, S_LOW} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          part_q;
  logic          wake_pend;

  wire           done     = (cnt == '0);
  wire [CW-1:0]  hold_len = part_q ? L_PART : L_FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OFF;
      cnt       <= '0;
      part_q    <= 1'b0;
      wake_pend <= 1'b0;
    end else begin
      case (st)
        S_OFF:
          if (start_i) begin
            st  <= S_PUP;
            cnt <= L_PWRUP;
          end
        S_PUP:
          if (done) begin
            st  <= S_HOLD;
            cnt <= L_FULL;
          end else cnt <= cnt - 1'b1;
        S_HOLD:
          if (done) st <= S_RDY;
          else cnt <= cnt - 1'b1;
        S_RDY: begin
          wake_pend <= 1'b0;
          if (sleep_req_i) begin
            st     <= S_PRE;
            cnt    <= L_SETUP;
            part_q <= partial_i;
          end
        end
        S_PRE:
          if (done) begin
            st  <= S_LOWMIN;
            cnt <= L_LOW;
          end else cnt <= cnt - 1'b1;
        S_LOWMIN: begin
          if (wake_req_i) wake_pend <= 1'b1;
          if (done) begin
            if (wake_pend || wake_req_i) begin
              st        <= S_HOLD;
              cnt       <= hold_len;
              wake_pend <= 1'b0;
            end else st <= S_LOW;
          end else cnt <= cnt - 1'b1;
        end
        S_LOW:
          if (wake_req_i) begin
            st  <= S_HOLD;
            cnt <= hold_len;
          end
        default: st <= S_OFF;
      endcase
    end
  end

  assign ce2_o      = !(st == S_OFF || st == S_PUP || st == S_LOWMIN || st == S_LOW);
  assign ready_o    = (st == S_RDY);
  assign ce1_hold_o = !ready_o;
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk #(
  parameter int LOW_MIN_CYC   = 7,
  parameter int PART_HOLD_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic ce2_o,
  input logic ce1_hold_o,
  input logic ready_o
);
  logic [31:0] lowrun, hirun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowrun <= '0;
      hirun  <= '0;
    end else begin
      lowrun <= ce2_o ? '0 : ((lowrun == '1) ? lowrun : lowrun + 1);
      hirun  <= ce2_o ? ((hirun == '1) ? hirun : hirun + 1) : '0;
    end
  end

  // R8
  ready_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (ce2_o && !ce1_hold_o));

  // R4
  fall_from_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce2_o) |-> ($past(ce1_hold_o) && !$past(ready_o)));

  // R5
  min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce2_o) |-> (lowrun >= 32'(LOW_MIN_CYC)));

  // R3
  hold_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (hirun >= 32'(PART_HOLD_CYC)));

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> (ce2_o && ce1_hold_o));

  // R7
  ready_keeps_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ce2_o);
endmodule

bind pwrdn_seq pwrdn_seq_chk #(
  .LOW_MIN_CYC  (LOW_MIN_CYC),
  .PART_HOLD_CYC(PART_HOLD_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce2_o     (ce2_o),
  .ce1_hold_o(ce1_hold_o),
  .ready_o   (ready_o)
);

// File: tb/pwrdn_seq_bench.sv
module pwrdn_seq_bench;
  localparam int SETUP = 2;
  localparam int LOWM  = 4;
  localparam int PUP   = 6;
  localparam int FULL  = 12;
  localparam int PART  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, sleep_req_i = 1'b0, wake_req_i = 1'b0, partial_i = 1'b0;
  logic ce2_o, ce1_hold_o, ready_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwrdn_seq #(
    .SETUP_CYC(SETUP), .LOW_MIN_CYC(LOWM), .PWRUP_LOW_CYC(PUP),
    .FULL_HOLD_CYC(FULL), .PART_HOLD_CYC(PART)
  ) u_pwrdn_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sleep_req_i(sleep_req_i),
    .wake_req_i(wake_req_i), .partial_i(partial_i),
    .ce2_o(ce2_o), .ce1_hold_o(ce1_hold_o), .ready_o(ready_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_pins(input string tag);
    chk(ce2_o == 1'b0 && ce1_hold_o == 1'b1 && ready_o == 1'b0, tag,
        {ce2_o, ce1_hold_o, ready_o}, 3'b010);
  endtask

  task automatic sleep_wake(input bit p, input int j);
    int a, l, h, exp_l;
    partial_i = p;
    sleep_req_i = 1'b1;
    @(negedge clk);
    sleep_req_i = 1'b0;
    partial_i = ~p;
    chk(ready_o == 1'b0 && ce1_hold_o == 1'b1, "R4 ready drop on sleep", ready_o, 0);
    a = 0;
    while (ce2_o) begin a++; @(negedge clk); end
    chk(a == SETUP, "R4 setup cycles before power enable falls", a, SETUP);
    l = 0;
    while (!ce2_o) begin
      l++;
      wake_req_i = (l == j);
      @(negedge clk);
    end
    wake_req_i = 1'b0;
    exp_l = (j > LOWM) ? j : LOWM;
    chk(l == exp_l, "R5 low duration", l, exp_l);
    h = 0;
    while (!ready_o) begin h++; @(negedge clk); end
    chk(h == (p ? PART : FULL), "R6 recovery hold", h, p ? PART : FULL);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_pins("R1 reset state");
    sleep_req_i = 1'b1; wake_req_i = 1'b1;
    @(negedge clk);
    sleep_req_i = 1'b0; wake_req_i = 1'b0;
    repeat (8) @(negedge clk);
    idle_pins("R1 held without start");

    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!ce2_o) begin n++; @(negedge clk); end
    chk(n == PUP, "R2 start-up low time", n, PUP);

    n = 0;
    while (!ready_o) begin
      sleep_req_i = (n == 2);
      start_i = (n == 3);
      n++;
      @(negedge clk);
    end
    sleep_req_i = 1'b0; start_i = 1'b0;
    chk(n == FULL, "R3 start-up hold", n, FULL);
    chk(ce1_hold_o == 1'b0 && ce2_o == 1'b1, "R3 override released with ready", ce1_hold_o, 0);
    repeat (3) @(negedge clk);
    chk(ready_o == 1'b1 && ce2_o == 1'b1, "R7 sleep during hold ignored", ready_o, 1);

    wake_req_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    wake_req_i = 1'b0; start_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(ready_o == 1'b1 && ce2_o == 1'b1, "R7 wake and start while ready ignored", ready_o, 1);
    chk(ce1_hold_o == 1'b0, "R8 override low while ready", ce1_hold_o, 0);

    for (int p = 0; p < 2; p++)
      for (int j = 1; j <= LOWM + 3; j++) begin
        sleep_wake(p[0], j);
        chk(ce2_o == 1'b1 && ce1_hold_o == 1'b0, "R8 pins after recovery", ce2_o, 1);
      end

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule